// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave Model

This block is a synthesizable behavioural model of a 1 Kbit serial EEPROM. It sits on a three-wire bus made of a chip select, a serial clock and a serial data input, and it answers on a data output that can be tri-stated. A configuration input chooses the view of the storage: either 64 words of 16 bits or 128 bytes of 8 bits. The storage itself lives in internal flip-flops.

The serial pins are sampled by the system clock. Rising serial-clock edges are found by comparing each sample with the one before it, so the serial clock has to run at least eight times slower than the system clock. Each frame opens with a start bit. A two-bit opcode follows, then an address, then write data when the command needs it. Reads answer at once. A programming command starts a self-timed cycle when chip select falls, and that cycle is counted in system clocks. While the cycle runs, raising chip select shows busy or ready on the data output.

Top module: `mw_eeprom`

## Requirements
- R1: After reset, the output enable is low, writes are disabled and every stored bit reads as 1.
- R2: A frame opens on the first rising serial-clock edge that sees chip select and data-in both high. Edges with data-in low before that do nothing.
- R3: All bits are sampled on rising serial-clock edges, MSB first. Opcode 10 is READ, 01 is WRITE and 11 is ERASE. Opcode 00 picks a command from the two top address bits: 11 enables writes, 00 disables writes, 10 erases all and 01 writes all. The other address bits are ignored.
- R4: With org=1 the address has 6 bits and the data 16 bits. With org=0 the address has 7 bits and the data 8 bits. Byte address 2w is the high byte of word w, and byte address 2w+1 is its low byte.
- R5: In a READ, the data output drives 0 after the edge that takes the last address bit. Each later edge then presents the next data bit, MSB first, and the last bit is held. The output is high-impedance whenever chip select is low.
- R6: Programming commands issued while writes are disabled change no data and start no busy period. Enable and disable commands take effect when chip select falls.
- R7: WRITE stores the data at the address. ERASE sets the addressed word or byte to all ones.
- R8: Erase-all sets every bit to 1. Write-all stores the data in every location; in x8 mode the same byte goes to every byte.
- R9: A command executes on the chip-select fall only if all of its required bits were clocked in. An earlier fall cancels it.
- R10: While programming runs and chip select is high, the output drives 0. It drives 1 once PROG_CYC system cycles have passed (ALL_CYC for the whole-array commands).
- R11: After programming, a start bit followed by chip select low returns the output to high-impedance.
- R12: Start bits arriving while programming runs are ignored, so the command that follows has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_cs | input | 1 | Chip select, active high |
| ser_clk | input | 1 | Serial bit clock |
| ser_di | input | 1 | Serial data in |
| org | input | 1 | Organization select: 1 = x16, 0 = x8 |
| ser_do | output | 1 | Serial data out |
| ser_do_oe | output | 1 | Output enable for ser_do; low means high-impedance |

## Verification
The hardest case to reach from the ports is a full command that arrives while a programming cycle is still running. To reach it, the bench lengthens the single-word cycle well past the time one 25-clock frame takes. It then sends a second WRITE right after the first chip-select fall and reads both addresses once ready returns. Cancelled frames are made by dropping chip select partway through the data bits. The byte-to-word mapping is checked by writing in one organization and reading back in the other.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [2:0] {
    C_NONE, C_WRITE, C_ERASE, C_ERAL, C_WRAL, C_EWEN, C_EWDS
  } mw_cmd_e;

  typedef enum logic [1:0] {
    F_IDLE, F_CMD, F_READ, F_FULL
  } mw_fe_e;
endpackage

// File: rtl/mw_rx.sv
module mw_rx
  import mw_pkg::*;
#(
  parameter int AW = 7,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          sclk,
  input  logic          di,
  input  logic          org,
  input  logic          busy,
  input  logic [DW-1:0] rd_word,
  output logic          exec,
  output logic          cs_end,
  output mw_cmd_e       cmd,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] wdata,
  output logic          in_read,
  output logic          fe_idle,
  output logic          rd_bit
);
  localparam int NW = $clog2(2 + AW + DW + 1);
  localparam int NR = $clog2(DW + 1);
  localparam int IW = $clog2(DW);

  mw_fe_e        st_q, st_d;
  logic [NW-1:0] n_q, n_d, len_a, len_d;
  logic [1:0]    op_q, op_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] dat_q, dat_d;
  logic [NR-1:0] rb_q, rb_d, rb_lim, idx;
  logic          sclk_q, rise;

  function automatic logic [1:0] ext_of(input logic [AW-1:0] a, input logic o);
    return o ? a[AW-2 -: 2] : a[AW-1 -: 2];
  endfunction

  function automatic mw_cmd_e decode(input logic [1:0] op, input logic [1:0] ex);
    case (op)
      2'b01:   return C_WRITE;
      2'b11:   return C_ERASE;
      2'b10:   return C_NONE;
      default: case (ex)
        2'b11:   return C_EWEN;
        2'b10:   return C_ERAL;
        2'b01:   return C_WRAL;
        default: return C_EWDS;
      endcase
    endcase
  endfunction

  assign rise   = sclk & ~sclk_q;
  assign len_a  = org ? NW'(1 + AW) : NW'(2 + AW);
  assign len_d  = org ? len_a + NW'(DW) : len_a + NW'(DW / 2);
  assign rb_lim = org ? NR'(DW) : NR'(DW / 2);

  always_comb begin
    st_d   = st_q;
    n_d    = n_q;
    op_d   = op_q;
    addr_d = addr_q;
    dat_d  = dat_q;
    rb_d   = rb_q;
    exec   = 1'b0;
    cs_end = 1'b0;
    if (!cs) begin
      if (st_q != F_IDLE) begin
        cs_end = 1'b1;
        exec   = (st_q == F_FULL);
        st_d   = F_IDLE;
      end
    end else if (rise) begin
      case (st_q)
        F_IDLE: if (di && !busy) begin
          st_d   = F_CMD;
          n_d    = '0;
          op_d   = '0;
          addr_d = '0;
          dat_d  = '0;
        end
        F_CMD: begin
          if (n_q < NW'(2))     op_d   = {op_q[0], di};
          else if (n_q < len_a) addr_d = {addr_q[AW-2:0], di};
          else                  dat_d  = {dat_q[DW-2:0], di};
          n_d = n_q + NW'(1);
          if (n_d == len_a) begin
            if (op_q == 2'b10) begin
              st_d = F_READ;
              rb_d = '0;
            end else if (!(op_q == 2'b01 ||
                           (op_q == 2'b00 && ext_of(addr_d, org) == 2'b01))) begin
              st_d = F_FULL;
            end
          end else if (n_d == len_d) begin
            st_d = F_FULL;
          end
        end
        F_READ: if (rb_q != rb_lim) rb_d = rb_q + NR'(1);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= F_IDLE;
      n_q    <= '0;
      op_q   <= '0;
      addr_q <= '0;
      dat_q  <= '0;
      rb_q   <= '0;
      sclk_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      n_q    <= n_d;
      op_q   <= op_d;
      addr_q <= addr_d;
      dat_q  <= dat_d;
      rb_q   <= rb_d;
      sclk_q <= sclk;
    end
  end

  assign idx     = rb_lim - rb_q;
  assign rd_bit  = (rb_q == '0) ? 1'b0 : rd_word[idx[IW-1:0]];
  assign cmd     = decode(op_q, ext_of(addr_q, org));
  assign addr    = addr_q;
  assign wdata   = dat_q;
  assign in_read = (st_q == F_READ);
  assign fe_idle = (st_q == F_IDLE);
endmodule

// File: rtl/mw_timer.sv
module mw_timer #(
  parameter int SHORT = 200,
  parameter int LONG  = 600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic long_sel,
  output logic busy,
  output logic done
);
  localparam int MX = (LONG > SHORT) ? LONG : SHORT;
  localparam int CW = $clog2(MX + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start)              cnt_d = long_sel ? CW'(LONG) : CW'(SHORT);
    else if (cnt_q != '0)   cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
  assign done = (cnt_q == CW'(1));
endmodule

// File: rtl/mw_array.sv
module mw_array
  import mw_pkg::*;
#(
  parameter int BYTES = 128,
  parameter int DW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          apply,
  input  mw_cmd_e       cmd,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          wr_org,
  input  logic [AW-1:0] rd_addr,
  input  logic          rd_org,
  output logic [DW-1:0] rd_word
);
  localparam int AW = $clog2(BYTES);
  localparam int BW = DW / 2;

  logic [BYTES-1:0][BW-1:0] mem_q;
  logic [BYTES-1:0][BW-1:0] nb;
  logic [BYTES-1:0]         we;

  for (genvar i = 0; i < BYTES; i++) begin : g_byte
    localparam logic [AW-1:0] IDX = AW'(i);
    logic          hit;
    logic [BW-1:0] src;
    assign hit = wr_org ? (addr[AW-2:0] == IDX[AW-1:1]) : (addr == IDX);
    assign src = (wr_org && !IDX[0]) ? wdata[DW-1 -: BW] : wdata[BW-1:0];
    assign we[i] = apply && (((cmd == C_WRITE || cmd == C_ERASE) && hit) ||
                             cmd == C_ERAL || cmd == C_WRAL);
    assign nb[i] = (cmd == C_WRITE || cmd == C_WRAL) ? src : {BW{1'b1}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= {BYTES{ {BW{1'b1}} }};
    end else begin
      for (int i = 0; i < BYTES; i++) begin
        if (we[i]) mem_q[i] <= nb[i];
      end
    end
  end

  assign rd_word = rd_org ? {mem_q[{rd_addr[AW-2:0], 1'b0}], mem_q[{rd_addr[AW-2:0], 1'b1}]}
                          : {{BW{1'b0}}, mem_q[rd_addr]};
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
  import mw_pkg::*;
#(
  parameter int BYTES    = 128,
  parameter int PROG_CYC = 200,
  parameter int ALL_CYC  = 600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_cs,
  input  logic ser_clk,
  input  logic ser_di,
  input  logic org,
  output logic ser_do,
  output logic ser_do_oe
);
  localparam int AW = $clog2(BYTES);
  localparam int DW = 16;

  logic          exec, cs_end, in_read, fe_idle, rd_bit, busy, done;
  mw_cmd_e       cmd;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rd_word;

  logic          wen_q, wen_d, stat_q, stat_d, prog;
  mw_cmd_e       pcmd_q;
  logic [AW-1:0] paddr_q;
  logic [DW-1:0] pdata_q;
  logic          porg_q;

  mw_rx #(.AW(AW), .DW(DW)) u_rx (
    .clk(clk), .rst_n(rst_n), .cs(ser_cs), .sclk(ser_clk), .di(ser_di),
    .org(org), .busy(busy), .rd_word(rd_word), .exec(exec), .cs_end(cs_end),
    .cmd(cmd), .addr(addr), .wdata(wdata), .in_read(in_read),
    .fe_idle(fe_idle), .rd_bit(rd_bit)
  );

  assign prog = exec && wen_q &&
                (cmd == C_WRITE || cmd == C_ERASE || cmd == C_ERAL || cmd == C_WRAL);

  mw_timer #(.SHORT(PROG_CYC), .LONG(ALL_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(prog),
    .long_sel(cmd == C_ERAL || cmd == C_WRAL), .busy(busy), .done(done)
  );

  mw_array #(.BYTES(BYTES), .DW(DW)) u_arr (
    .clk(clk), .rst_n(rst_n), .apply(done), .cmd(pcmd_q), .addr(paddr_q),
    .wdata(pdata_q), .wr_org(porg_q), .rd_addr(addr), .rd_org(org),
    .rd_word(rd_word)
  );

  always_comb begin
    wen_d  = wen_q;
    stat_d = stat_q;
    if (exec && cmd == C_EWEN) wen_d = 1'b1;
    if (exec && cmd == C_EWDS) wen_d = 1'b0;
    if (prog)        stat_d = 1'b1;
    else if (cs_end) stat_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wen_q   <= 1'b0;
      stat_q  <= 1'b0;
      pcmd_q  <= C_NONE;
      paddr_q <= '0;
      pdata_q <= '0;
      porg_q  <= 1'b0;
    end else begin
      wen_q  <= wen_d;
      stat_q <= stat_d;
      if (prog) begin
        pcmd_q  <= cmd;
        paddr_q <= addr;
        pdata_q <= wdata;
        porg_q  <= org;
      end
    end
  end

  assign ser_do_oe = ser_cs && (in_read || stat_q);
  assign ser_do    = in_read ? rd_bit : ~busy;
endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk (
  input logic clk,
  input logic rst_n,
  input logic ser_cs,
  input logic ser_do,
  input logic ser_do_oe,
  input logic busy,
  input logic fe_idle,
  input logic in_read,
  input logic wen_q,
  input logic cs_end
);
  // R5
  hiz_when_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_cs |-> !ser_do_oe);

  // R5
  read_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_read && ser_cs |-> ser_do_oe);

  // R10
  busy_shows_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && ser_cs |-> ser_do_oe && !ser_do);

  // R12
  busy_blocks_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> fe_idle);

  // R6
  prog_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wen_q));

  // R9
  prog_on_cs_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_end) && $past(!ser_cs));
endmodule

bind mw_eeprom mw_eeprom_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ser_cs(ser_cs), .ser_do(ser_do),
  .ser_do_oe(ser_do_oe), .busy(busy), .fe_idle(fe_idle), .in_read(in_read),
  .wen_q(wen_q), .cs_end(cs_end)
);

// File: tb/sim_mw_eeprom.sv
module sim_mw_eeprom;
  localparam int PROG = 1500;
  localparam int ALL  = 4000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sclk = 1'b0, di = 1'b0, org = 1'b1;
  logic dout, doe;
  int   checks = 0, errors = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  mw_eeprom #(.BYTES(128), .PROG_CYC(PROG), .ALL_CYC(ALL)) u0 (
    .clk(clk), .rst_n(rst_n), .ser_cs(cs), .ser_clk(sclk), .ser_di(di),
    .org(org), .ser_do(dout), .ser_do_oe(doe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick();
    sclk = 1'b1; wait_n(4);
    sclk = 1'b0; wait_n(4);
  endtask

  task automatic shift(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      di = v[i];
      tick();
    end
  endtask

  function automatic int aw(); return org ? 6 : 7; endfunction
  function automatic int dw(); return org ? 16 : 8; endfunction

  task automatic send(input logic [1:0] op, input logic [31:0] a, input logic [31:0] d,
                      input bit with_data);
    cs = 1'b1; wait_n(2);
    shift(32'd1, 1);
    shift({30'd0, op}, 2);
    shift(a, aw());
    if (with_data) shift(d, dw());
    di = 1'b0; cs = 1'b0; wait_n(4);
  endtask

  task automatic ext_cmd(input logic [1:0] code);
    send(2'b00, org ? {code, 4'b0} : {code, 5'b0}, 0, 1'b0);
  endtask

  task automatic rd(input logic [31:0] a, input int lead, output logic [31:0] w,
                    output logic dummy);
    cs = 1'b1; wait_n(2);
    shift(0, lead);
    shift(32'd1, 1);
    shift(32'd2, 2);
    shift(a, aw());
    dummy = doe ? dout : 1'bz;
    w = 0;
    for (int i = 0; i < dw(); i++) begin
      tick();
      w = {w[30:0], (doe ? dout : 1'bz)};
    end
    di = 1'b0; cs = 1'b0; wait_n(4);
  endtask

  task automatic ready_wait(input string req, input int exp_len);
    int n = 0;
    cs = 1'b1; wait_n(2);
    chk({req, " busy shows 0"}, {doe, dout}, 2'b10);
    while (dout !== 1'b1 && n < 20000) begin
      @(negedge clk); n++;
    end
    chk({req, " ready shows 1"}, {doe, dout}, 2'b11);
    if (exp_len > 0) chk({req, " busy length"}, (n > exp_len - 20 && n <= exp_len), 1);
    di = 1'b1; tick(); di = 1'b0;
    cs = 1'b0; wait_n(4);
    cs = 1'b1; wait_n(2);
    chk("R11 status cleared", doe, 0);
    cs = 1'b0; wait_n(4);
  endtask

  task automatic no_busy(input string req);
    cs = 1'b1; wait_n(2);
    chk(req, doe, 0);
    cs = 1'b0; wait_n(4);
  endtask

  task automatic t_reset();
    logic [31:0] w; logic dm;
    chk("R1 oe low after reset", doe, 0);
    rd(0, 0, w, dm);
    chk("R5 dummy zero", dm, 0);
    chk("R1 erased content", w, 32'hFFFF);
  endtask

  task automatic t_protect();
    logic [31:0] w; logic dm;
    send(2'b01, 3, 32'h1111, 1'b1);
    no_busy("R6 disabled write no busy");
    rd(3, 0, w, dm);
    chk("R6 disabled write no change", w, 32'hFFFF);
  endtask

  task automatic t_write();
    logic [31:0] w; logic dm;
    ext_cmd(2'b11);
    send(2'b01, 5, 32'hA5C3, 1'b1);
    ready_wait("R10 write", PROG);
    rd(5, 3, w, dm);
    chk("R2 leading zeros ignored, R7 write", w, 32'hA5C3);
    chk("R5 dummy before data", dm, 0);
  endtask

  task automatic t_x8();
    logic [31:0] w; logic dm;
    org = 1'b0; wait_n(2);
    rd(10, 0, w, dm);
    chk("R4 high byte", w, 32'hA5);
    rd(11, 0, w, dm);
    chk("R4 low byte", w, 32'hC3);
    send(2'b01, 20, 32'h3C, 1'b1);
    ready_wait("R10 x8 write", 0);
    rd(20, 0, w, dm);
    chk("R7 x8 write", w, 32'h3C);
    rd(21, 0, w, dm);
    chk("R4 neighbour byte unchanged", w, 32'hFF);
    org = 1'b1; wait_n(2);
    rd(10, 0, w, dm);
    chk("R4 bytes form word", w, 32'h3CFF);
  endtask

  task automatic t_erase();
    logic [31:0] w; logic dm;
    send(2'b11, 5, 0, 1'b0);
    ready_wait("R10 erase", PROG);
    rd(5, 0, w, dm);
    chk("R7 erase", w, 32'hFFFF);
  endtask

  task automatic t_abort();
    logic [31:0] w; logic dm;
    cs = 1'b1; wait_n(2);
    shift(32'd1, 1); shift(32'd1, 2); shift(8, 6); shift(32'h155, 10);
    di = 1'b0; cs = 1'b0; wait_n(4);
    no_busy("R9 short frame no busy");
    rd(8, 0, w, dm);
    chk("R9 short frame no change", w, 32'hFFFF);
  endtask

  task automatic t_busy();
    logic [31:0] w; logic dm;
    send(2'b01, 6, 32'h0F0F, 1'b1);
    send(2'b01, 7, 32'h7777, 1'b1);
    ready_wait("R10 busy case", 0);
    rd(7, 0, w, dm);
    chk("R12 command during busy ignored", w, 32'hFFFF);
    rd(6, 0, w, dm);
    chk("R7 first write kept", w, 32'h0F0F);
  endtask

  task automatic t_all();
    logic [31:0] w; logic dm;
    ext_cmd(2'b01);
    shift(0, 0);
    send(2'b00, 6'b010000, 32'h1234, 1'b1);
    ready_wait("R10 write-all", ALL);
    rd(0, 0, w, dm);
    chk("R8 write-all first", w, 32'h1234);
    rd(63, 0, w, dm);
    chk("R8 write-all last", w, 32'h1234);
    ext_cmd(2'b10);
    ready_wait("R10 erase-all", ALL);
    rd(30, 0, w, dm);
    chk("R8 erase-all", w, 32'hFFFF);
  endtask

  task automatic t_disable();
    logic [31:0] w; logic dm;
    ext_cmd(2'b00);
    send(2'b01, 9, 32'h5555, 1'b1);
    no_busy("R6 after disable no busy");
    rd(9, 0, w, dm);
    chk("R3 R6 disable command", w, 32'hFFFF);
  endtask

  initial begin
    wait_n(5);
    rst_n = 1'b1;
    wait_n(3);
    t_reset();
    t_protect();
    t_write();
    t_x8();
    t_erase();
    t_abort();
    t_busy();
    t_disable();
    ext_cmd(2'b11);
    t_all();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule